// File: doc/BRIEF.md
# Linear Address Breakpoint Unit

This block watches the stream of linear addresses produced by a processor core and compares each valid address against four programmable watch addresses. When an address equals a watch address whose breakpoint is armed, the block records which breakpoint hit in a sticky hit register. In the following cycle it raises a one-cycle exception request that carries a fixed vector number.

Software programs the unit through a simple register port. The port has a write strobe, a 3-bit select, write data and combinational read data. The four watch addresses sit at selects 0 to 3, the hit register at select 4 and the arm register at select 5. Each breakpoint has two arm bits, a local one and a global one, and either bit is enough to arm it. Delivering the exception to the core is left to the surrounding logic.

Top module: `lin_bkpt_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every watch address, the arm register and the hit register clear to zero, and `exc_req` is low after that edge.
- R2: A write with `cfg_sel` 0 to 3 stores the full 32-bit `cfg_wdata` in watch slot n = `cfg_sel`, and reading the same select returns it.
- R3: Select 5 is the arm register and keeps bits [7:0]. Select 4 is the hit register and keeps bits [3:0]. Unkept bits read as zero, and selects 6 and 7 read as zero.
- R4: Breakpoint n is armed when arm bit 2n (local) or bit 2n+1 (global) is set. A matching address on an unarmed breakpoint sets no hit flag and raises no request.
- R5: When `addr_vld` is high and `addr_lin` equals the address of an armed slot n, hit bit n reads as set after the next rising edge, and `exc_req` is high for exactly that one following cycle.
- R6: When several armed slots match the same address, all of their hit bits are set together and a single one-cycle request is raised.
- R7: Hit bits stay set until software writes the hit register. A write to the hit register replaces it with `cfg_wdata[3:0]`, and writing zero clears it.
- R8: When a hit register write and a new hit happen in the same cycle, the new hit bits are ORed over the written value.
- R9: When `addr_vld` is low, `addr_lin` has no effect on hit bits or on `exc_req`.
- R10: `exc_vec` equals 1 while `exc_req` is high and equals 0 otherwise.
- R11: An address is compared against the register values held before the edge, so a register write in the same cycle affects only later addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0-3 watch slots, 4 hit, 5 arm) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the selected register |
| addr_vld | input | 1 | Linear address valid |
| addr_lin | input | 32 | Linear address generated by the core |
| exc_req | output | 1 | One-cycle debug exception request |
| exc_vec | output | 8 | Exception vector number, 1 during a request |

## Verification
The compare path is driven with three kinds of address. Addresses copied from programmed slots must hit. Random addresses must miss, which shows the comparison uses all 32 bits and is not a partial decode. Addresses presented with `addr_vld` low show that the valid qualifier gates everything. Directed cases program two slots with the same address to show that one request with two hit bits is raised. Other directed cases arm slots through only the local bit or only the global bit, and overlap a register write with a compare in the same cycle, which separates old-value from new-value comparison and shows whether a hit or a clear wins on the hit register.

// File: rtl/bkpt_pkg.sv
// Shared constants and helpers for the linear address breakpoint unit.
// Assumes two arm bits per breakpoint, held next to each other.
package bkpt_pkg;
    localparam int unsigned ARM_BITS = 2;

    // True when either the local or the global arm bit of a slot is set.
    function automatic logic slot_armed(input logic [ARM_BITS-1:0] en);
        return |en;
    endfunction
endpackage

// File: rtl/bkpt_regs.sv
// Register file: watch address slots, arm register and sticky hit register.
// Assumes writes and hit updates land on the same clock edge; hits win over a write.
module bkpt_regs #(
    parameter int unsigned NUM_BP = 4,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SEL_W  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [SEL_W-1:0]                  sel,
    input  logic [ADDR_W-1:0]                 wdata,
    input  logic [NUM_BP-1:0]                 set_hits,
    output logic [ADDR_W-1:0]                 rdata,
    output logic [NUM_BP-1:0][ADDR_W-1:0]     slot_addr,
    output logic [bkpt_pkg::ARM_BITS*NUM_BP-1:0] arm_q,
    output logic [NUM_BP-1:0]                 hit_q
);
    localparam int unsigned ARM_W   = bkpt_pkg::ARM_BITS * NUM_BP;
    localparam logic [SEL_W-1:0] SEL_HIT = SEL_W'(NUM_BP);
    localparam logic [SEL_W-1:0] SEL_ARM = SEL_W'(NUM_BP + 1);

    // One register per watch slot, written when its select matches.
    for (genvar n = 0; n < NUM_BP; n++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_addr[n] <= '0;
            else if (wr_en && sel == SEL_W'(n))
                slot_addr[n] <= wdata;
        end
    end

    // Arm register keeps only the per-slot enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm_q <= '0;
        else if (wr_en && sel == SEL_ARM)
            arm_q <= wdata[ARM_W-1:0];
    end

    // Sticky hit flags: software write replaces them, new hits are ORed on top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hit_q <= '0;
        else
            hit_q <= ((wr_en && sel == SEL_HIT) ? wdata[NUM_BP-1:0] : hit_q) | set_hits;
    end

    // Read mux; unused selects and unkept bits return zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_BP; i++) begin
            if (sel == SEL_W'(i))
                rdata = slot_addr[i];
        end
        if (sel == SEL_HIT)
            rdata[NUM_BP-1:0] = hit_q;
        if (sel == SEL_ARM)
            rdata[ARM_W-1:0] = arm_q;
    end

    // Without a hit register write, no hit flag ever drops.
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_HIT) |=> ((hit_q & $past(hit_q)) == $past(hit_q)));

    // A requested hit is always visible on the next cycle, even over a write.
    assert_hit_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((hit_q & $past(set_hits)) == $past(set_hits)));
endmodule

// File: rtl/bkpt_match.sv
// Per-slot address comparators and arm decode.
// Assumes the address and slot values are stable for the cycle they are compared in.
module bkpt_match #(
    parameter int unsigned NUM_BP = 4,
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]                    addr,
    input  logic [NUM_BP-1:0][ADDR_W-1:0]        slot_addr,
    input  logic [bkpt_pkg::ARM_BITS*NUM_BP-1:0] arm,
    output logic [NUM_BP-1:0]                    match,
    output logic [NUM_BP-1:0]                    armed
);
    // One equality comparator and one arm decode per slot.
    for (genvar n = 0; n < NUM_BP; n++) begin : g_cmp
        assign match[n] = (addr == slot_addr[n]);
        assign armed[n] = bkpt_pkg::slot_armed(arm[bkpt_pkg::ARM_BITS*n +: bkpt_pkg::ARM_BITS]);
    end
endmodule

// File: rtl/bkpt_req.sv
// Qualifies matches with valid and arm, and registers a one-cycle exception request.
// Assumes one request per valid cycle, however many slots match.
module bkpt_req #(
    parameter int unsigned NUM_BP = 4,
    parameter int unsigned VEC_W  = 8,
    parameter int unsigned VECTOR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_vld,
    input  logic [NUM_BP-1:0] match,
    input  logic [NUM_BP-1:0] armed,
    output logic [NUM_BP-1:0] set_hits,
    output logic              req,
    output logic [VEC_W-1:0]  vec
);
    // Slots that hit in this cycle.
    always_comb set_hits = addr_vld ? (match & armed) : '0;

    // Request register: high for the cycle after any qualified hit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req <= 1'b0;
        else
            req <= |set_hits;
    end

    // Vector is driven only while a request is raised.
    always_comb vec = req ? VEC_W'(VECTOR) : '0;

    // Any armed match under valid must raise the request next cycle.
    assert_hit_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && |(match & armed)) |=> req);

    // No armed match means no request, regardless of address.
    assert_unarmed_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (((match & armed) == '0) || !addr_vld) |=> !req);

    // A request is always preceded by a valid address.
    assert_req_needs_vld_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(addr_vld));
endmodule

// File: rtl/lin_bkpt_unit.sv
// Top of the linear address breakpoint unit: register file, comparators, request stage.
// Assumes a synchronous active-low reset and a single clock domain.
module lin_bkpt_unit #(
    parameter int unsigned NUM_BP = 4,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned VEC_W  = 8,
    parameter int unsigned VECTOR = 1,
    parameter int unsigned SEL_W  = $clog2(NUM_BP + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] addr_lin,
    output logic              exc_req,
    output logic [VEC_W-1:0]  exc_vec
);
    localparam int unsigned ARM_W = bkpt_pkg::ARM_BITS * NUM_BP;

    logic [NUM_BP-1:0][ADDR_W-1:0] slot_addr;
    logic [ARM_W-1:0]              arm_q;
    logic [NUM_BP-1:0]             hit_q;
    logic [NUM_BP-1:0]             match;
    logic [NUM_BP-1:0]             armed;
    logic [NUM_BP-1:0]             set_hits;

    bkpt_regs #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .set_hits(set_hits), .rdata(cfg_rdata), .slot_addr(slot_addr),
        .arm_q(arm_q), .hit_q(hit_q)
    );

    bkpt_match #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W)) u_match (
        .addr(addr_lin), .slot_addr(slot_addr), .arm(arm_q),
        .match(match), .armed(armed)
    );

    bkpt_req #(.NUM_BP(NUM_BP), .VEC_W(VEC_W), .VECTOR(VECTOR)) u_req (
        .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .match(match), .armed(armed),
        .set_hits(set_hits), .req(exc_req), .vec(exc_vec)
    );

    // Vector output tracks the request flag.
    assert_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req == (exc_vec == VEC_W'(VECTOR)));

    // Reset leaves the request and hit flags clear.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!exc_req && hit_q == '0));
endmodule

// File: tb/sim_lin_bkpt_unit.sv
module sim_lin_bkpt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        addr_vld = 1'b0;
    logic [31:0] addr_lin = '0;
    logic        exc_req;
    logic [7:0]  exc_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] m_slot [4];
    logic [7:0]  m_arm;
    logic [3:0]  m_hit;
    logic        m_req;

    always #10 clk = ~clk;

    lin_bkpt_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .addr_vld(addr_vld),
        .addr_lin(addr_lin), .exc_req(exc_req), .exc_vec(exc_vec)
    );

    function automatic logic [31:0] m_read(input logic [2:0] s);
        if (s < 3'd4) return m_slot[s[1:0]];
        if (s == 3'd4) return {28'd0, m_hit};
        if (s == 3'd5) return {24'd0, m_arm};
        return 32'd0;
    endfunction

    function automatic logic [3:0] m_hits_for(input logic v, input logic [31:0] a);
        logic [3:0] h = '0;
        for (int n = 0; n < 4; n++)
            h[n] = v && (a == m_slot[n]) && (m_arm[2*n +: 2] != 2'b00);
        return h;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock cycle of stimulus, then compare request, vector and read data.
    task automatic step(input string tag, input logic v, input logic [31:0] a,
                        input logic we, input logic [2:0] s, input logic [31:0] wd);
        logic [3:0] nh;
        @(negedge clk);
        addr_vld = v; addr_lin = a; cfg_we = we; cfg_sel = s; cfg_wdata = wd;
        nh = m_hits_for(v, a);
        if (we) begin
            if (s < 3'd4) m_slot[s[1:0]] = wd;
            else if (s == 3'd4) m_hit = wd[3:0];
            else if (s == 3'd5) m_arm = wd[7:0];
        end
        m_hit = m_hit | nh;
        m_req = |nh;
        @(posedge clk);
        #2;
        check({tag, " req"}, {31'd0, exc_req}, {31'd0, m_req});
        check({tag, " R10 vec"}, {24'd0, exc_vec}, m_req ? 32'd1 : 32'd0);
        check({tag, " rdata"}, cfg_rdata, m_read(s));
        @(negedge clk);
        cfg_we = 1'b0; addr_vld = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] s);
        @(negedge clk);
        cfg_we = 1'b0; addr_vld = 1'b0; cfg_sel = s;
        #2;
        check(tag, cfg_rdata, m_read(s));
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        for (int n = 0; n < 4; n++) m_slot[n] = '0;
        m_arm = '0; m_hit = '0; m_req = 1'b0;

        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1 req", {31'd0, exc_req}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        for (int s = 0; s < 8; s++) rd("R1 reset read", 3'(s));

        // R2: slot write and read back
        step("R2 slot0", 0, 0, 1, 3'd0, 32'hDEAD_BEEF);
        step("R2 slot1", 0, 0, 1, 3'd1, 32'h1234_5678);
        step("R2 slot2", 0, 0, 1, 3'd2, 32'hFFFF_FFFF);
        step("R2 slot3", 0, 0, 1, 3'd3, 32'h0000_1000);

        // R3: field widths and unused selects
        step("R3 arm", 0, 0, 1, 3'd5, 32'hFFFF_FFFF);
        step("R3 hit", 0, 0, 1, 3'd4, 32'hFFFF_FFFF);
        step("R3 sel6", 0, 0, 1, 3'd6, 32'hFFFF_FFFF);
        rd("R3 sel7", 3'd7);
        step("R3 clear hit", 0, 0, 1, 3'd4, 32'd0);
        step("R3 clear arm", 0, 0, 1, 3'd5, 32'd0);

        // R4: unarmed match ignored, local-only and global-only arming
        step("R4 unarmed", 1, 32'hDEAD_BEEF, 0, 3'd4, 0);
        step("R4 arm global0", 0, 0, 1, 3'd5, 32'h0000_0002);
        step("R4 global hit", 1, 32'hDEAD_BEEF, 0, 3'd4, 0);
        step("R4 arm local3", 0, 0, 1, 3'd5, 32'h0000_0040);
        step("R4 slot0 now off", 1, 32'hDEAD_BEEF, 0, 3'd4, 0);
        step("R5 local hit", 1, 32'h0000_1000, 0, 3'd4, 0);
        step("R5 pulse ends", 0, 0, 0, 3'd4, 0);

        // R6: two slots share an address
        step("R6 clear", 0, 0, 1, 3'd4, 0);
        step("R6 slot1", 0, 0, 1, 3'd1, 32'hCAFE_0000);
        step("R6 slot2", 0, 0, 1, 3'd2, 32'hCAFE_0000);
        step("R6 arm all", 0, 0, 1, 3'd5, 32'h0000_00FF);
        step("R6 double hit", 1, 32'hCAFE_0000, 0, 3'd4, 0);
        step("R6 single pulse", 0, 0, 0, 3'd4, 0);

        // R7: sticky until cleared
        step("R7 idle1", 0, 0, 0, 3'd4, 0);
        step("R7 miss", 1, 32'h0BAD_0BAD, 0, 3'd4, 0);
        step("R7 clear", 0, 0, 1, 3'd4, 0);

        // R8: hit beats a clearing write in the same cycle
        step("R8 hit over clear", 1, 32'hDEAD_BEEF, 1, 3'd4, 0);

        // R9: matching address without valid
        step("R9 clear", 0, 0, 1, 3'd4, 0);
        step("R9 no valid", 0, 32'hDEAD_BEEF, 0, 3'd4, 0);

        // R11: slot rewritten in the same cycle as a match on its old value
        step("R11 old value hit", 1, 32'hDEAD_BEEF, 1, 3'd0, 32'h5555_0000);
        step("R11 old value gone", 1, 32'hDEAD_BEEF, 0, 3'd4, 0);
        step("R11 new value hit", 1, 32'h5555_0000, 0, 3'd4, 0);

        // R5/R7: random mix of hits, misses and writes
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic [2:0]  s;
            logic        w;
            a = ($urandom % 2) ? m_slot[$urandom % 4] : $urandom;
            w = ($urandom % 6) == 0;
            s = 3'($urandom % 6);
            if (!w) s = 3'd4;
            step("R5 random", 1'($urandom % 3 != 0), a, w, s, $urandom);
        end

        // R1: reset in the middle of activity
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #2;
        check("R1 req after reset", {31'd0, exc_req}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        for (int n = 0; n < 4; n++) m_slot[n] = '0;
        m_arm = '0; m_hit = '0;
        rd("R1 hit after reset", 3'd4);
        rd("R1 arm after reset", 3'd5);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule